// File: doc/BRIEF.md
# Tag-Extended Cache Line Store

This block is the data array of a cache in which every 64-bit double word carries a small metadata tag of `TAG_W` bits. The tag sits in the storage slot right beside its word. A line of `WORDS` double words therefore occupies `WORDS*(64+TAG_W)` bits. With eight words and 4-bit tags, that is 544 bits instead of 512.

The array serves three request ports:

- **Line port.** Moves a whole line, data and tags together, for refill and writeback.
- **Word port.** Reads or writes only the 64 data bits of one double word.
- **Tag port.** Carries load-tag and store-tag operations. Each of these supplies a base register value and a signed 12-bit offset. The block adds them to form the effective address and checks that the address is aligned to 8 bytes. It then reads or writes only the tag bits of the selected word.

Hit detection, replacement and coherence live elsewhere. The set, the way and a hit flag arrive on the ports.

At most one request is served per clock. All read results and tag-port flags are registered and appear one cycle after the request.

Top module: `tagline_store`

## Requirements
- R1: A line is stored and returned as `WORDS` slots of `64+TAG_W` bits. Slot `w` occupies bits `[w*(64+TAG_W) +: 64+TAG_W]`, with the data in its low 64 bits and the tag directly above. A line write followed by a line read of the same set and way returns the identical line on `ln_rdata` one cycle after the read request.
- R2: The tag-port effective address is `tg_base` plus `tg_imm` sign-extended to 64 bits, wrapping modulo 2^64. The addressed word within the line is `EA[3 +: log2(WORDS)]`.
- R3: A hit, aligned store-tag (`tg_st`=1) writes `tg_src[TAG_W-1:0]` into the tag of the addressed word. Higher bits of `tg_src` have no effect.
- R4: A hit, aligned load-tag (`tg_st`=0) returns the addressed tag zero-extended to 64 bits on `tg_result`, with `tg_done` high for exactly the following cycle.
- R5: A tag request whose effective address has `EA[2:0]` != 0 raises `tg_misalign` for one cycle. It does not raise `tg_done` and changes no stored bit.
- R6: A store-tag leaves the 64 data bits of the word unchanged.
- R7: A word-port write changes only the 64 data bits of the word and keeps its tag. A word-port read returns those data bits on `dw_rdata` one cycle later.
- R8: A tag request with `tg_hit` low changes nothing and gives no `tg_done`. A misaligned address still raises `tg_misalign`.
- R9: When several ports request in one cycle, the line port wins over the word port, and the word port wins over the tag port. The losing requests are ignored entirely.
- R10: After reset, `tg_done` and `tg_misalign` are low, and `tg_result`, `dw_rdata` and `ln_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ln_req | input | 1 | Line transfer request |
| ln_we | input | 1 | Line transfer is a write |
| ln_set | input | SET_W | Set of the line transfer |
| ln_way | input | WAY_W | Way of the line transfer |
| ln_wdata | input | LINE_W | Line to write, data and tags |
| ln_rdata | output | LINE_W | Line read result |
| dw_req | input | 1 | Double-word data request |
| dw_we | input | 1 | Double-word request is a write |
| dw_set | input | SET_W | Set of the word request |
| dw_way | input | WAY_W | Way of the word request |
| dw_idx | input | IDX_W | Word index within the line |
| dw_wdata | input | 64 | Data to write |
| dw_rdata | output | 64 | Data read result |
| tg_req | input | 1 | Tag operation request |
| tg_st | input | 1 | 1 = store-tag, 0 = load-tag |
| tg_hit | input | 1 | Line is present (from the tag lookup) |
| tg_set | input | SET_W | Set of the tag request |
| tg_way | input | WAY_W | Way of the tag request |
| tg_base | input | 64 | Base register value |
| tg_imm | input | 12 | Signed address offset |
| tg_src | input | 64 | Source register value for store-tag |
| tg_result | output | 64 | Zero-extended tag for load-tag |
| tg_done | output | 1 | Tag operation completed |
| tg_misalign | output | 1 | Misalignment fault |

## Verification
The bench builds the block with `TAG_W`=4, `WORDS`=8, `SETS`=4 and `WAYS`=2. That gives eight 544-bit lines, so every set and way combination can be preloaded with a distinct pattern and tracked in a bench-side model. The 4-bit tag width makes the masking of the upper source bits and the zero extension of results visible. The eight-word line lets offsets such as +2040 and -2048 wrap into chosen word slots. Line readback after tag stores confirms that each tag lands at the bit position the slot layout defines.

// File: rtl/tls_pkg.sv
package tls_pkg;
    localparam int DW    = 64;
    localparam int IMM_W = 12;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LINE_RD,
        OP_LINE_WR,
        OP_WORD_RD,
        OP_WORD_WR,
        OP_TAG_LD,
        OP_TAG_ST
    } op_e;
endpackage

// File: rtl/tls_agen.sv
module tls_agen
    import tls_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [DW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    output logic             aligned,
    output logic [IDX_W-1:0] word_idx
);
    logic [DW-1:0] eff_addr;

    always_comb begin
        eff_addr = base + {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
        aligned  = (eff_addr[2:0] == 3'b000);
        word_idx = eff_addr[3 +: IDX_W];
    end
endmodule

// File: rtl/tls_array.sv
module tls_array #(
    parameter int LINES  = 8,
    parameter int LINE_W = 544,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [LINE_W-1:0] wr_mask,
    input  logic [AW-1:0]     rd_addr,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= (mem_q[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assign rd_line = mem_q[rd_addr];
endmodule

// File: rtl/tagline_store.sv
module tagline_store
    import tls_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int WORDS = 8,
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    localparam int SLOT_W = DW + TAG_W,
    localparam int LINE_W = WORDS * SLOT_W,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINES  = SETS * WAYS,
    localparam int LA_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ln_req,
    input  logic              ln_we,
    input  logic [SET_W-1:0]  ln_set,
    input  logic [WAY_W-1:0]  ln_way,
    input  logic [LINE_W-1:0] ln_wdata,
    output logic [LINE_W-1:0] ln_rdata,
    input  logic              dw_req,
    input  logic              dw_we,
    input  logic [SET_W-1:0]  dw_set,
    input  logic [WAY_W-1:0]  dw_way,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [DW-1:0]     dw_wdata,
    output logic [DW-1:0]     dw_rdata,
    input  logic              tg_req,
    input  logic              tg_st,
    input  logic              tg_hit,
    input  logic [SET_W-1:0]  tg_set,
    input  logic [WAY_W-1:0]  tg_way,
    input  logic [DW-1:0]     tg_base,
    input  logic [IMM_W-1:0]  tg_imm,
    input  logic [DW-1:0]     tg_src,
    output logic [DW-1:0]     tg_result,
    output logic              tg_done,
    output logic              tg_misalign
);
    typedef struct packed {
        logic [LINE_W-1:0] ln_rdata;
        logic [DW-1:0]     dw_rdata;
        logic [DW-1:0]     tg_result;
        logic              tg_done;
        logic              tg_fault;
    } out_t;

    out_t              o_d, o_q;
    op_e               op;
    logic [LA_W-1:0]   sel_line;
    logic [IDX_W-1:0]  sel_idx;
    logic              ag_aligned;
    logic [IDX_W-1:0]  ag_idx;
    logic [LINE_W-1:0] rd_line;
    logic [SLOT_W-1:0] slot [WORDS];
    logic [SLOT_W-1:0] cur_slot;
    logic              wr_en;
    logic [LINE_W-1:0] wr_data, wr_mask;
    int unsigned       shamt;

    function automatic logic [LA_W-1:0] line_of(input logic [SET_W-1:0] s,
                                                 input logic [WAY_W-1:0] w);
        return LA_W'(s) * LA_W'(WAYS) + LA_W'(w);
    endfunction

    tls_agen #(.IDX_W(IDX_W)) u_agen (
        .base     (tg_base),
        .imm      (tg_imm),
        .aligned  (ag_aligned),
        .word_idx (ag_idx)
    );

    tls_array #(.LINES(LINES), .LINE_W(LINE_W), .AW(LA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (sel_line),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_addr (sel_line),
        .rd_line (rd_line)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        assign slot[g] = rd_line[g*SLOT_W +: SLOT_W];
    end

    // Port arbitration: line over word over tag.
    always_comb begin
        op       = OP_IDLE;
        sel_line = '0;
        sel_idx  = '0;
        if (ln_req) begin
            op       = ln_we ? OP_LINE_WR : OP_LINE_RD;
            sel_line = line_of(ln_set, ln_way);
        end else if (dw_req) begin
            op       = dw_we ? OP_WORD_WR : OP_WORD_RD;
            sel_line = line_of(dw_set, dw_way);
            sel_idx  = dw_idx;
        end else if (tg_req) begin
            op       = tg_st ? OP_TAG_ST : OP_TAG_LD;
            sel_line = line_of(tg_set, tg_way);
            sel_idx  = ag_idx;
        end
    end

    // Next outputs and masked write toward the array.
    always_comb begin
        cur_slot = slot[sel_idx];
        shamt    = 32'(sel_idx) * 32'(SLOT_W);
        o_d          = o_q;
        o_d.tg_done  = 1'b0;
        o_d.tg_fault = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        wr_mask = '0;
        unique case (op)
            OP_LINE_RD: o_d.ln_rdata = rd_line;
            OP_LINE_WR: begin
                wr_en   = 1'b1;
                wr_data = ln_wdata;
                wr_mask = '1;
            end
            OP_WORD_RD: o_d.dw_rdata = cur_slot[DW-1:0];
            OP_WORD_WR: begin
                wr_en   = 1'b1;
                wr_data = LINE_W'(dw_wdata) << shamt;
                wr_mask = LINE_W'({DW{1'b1}}) << shamt;
            end
            OP_TAG_LD, OP_TAG_ST: begin
                if (!ag_aligned) begin
                    o_d.tg_fault = 1'b1;
                end else if (tg_hit) begin
                    o_d.tg_done = 1'b1;
                    if (op == OP_TAG_LD) begin
                        o_d.tg_result = DW'(cur_slot[SLOT_W-1:DW]);
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = LINE_W'({tg_src[TAG_W-1:0], {DW{1'b0}}}) << shamt;
                        wr_mask = LINE_W'({{TAG_W{1'b1}}, {DW{1'b0}}}) << shamt;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ln_rdata    = o_q.ln_rdata;
    assign dw_rdata    = o_q.dw_rdata;
    assign tg_result   = o_q.tg_result;
    assign tg_done     = o_q.tg_done;
    assign tg_misalign = o_q.tg_fault;

    AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tg_misalign |-> !tg_done); // R5
    AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tg_misalign |-> $past(tg_req)); // R5
    AST_DONE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        tg_done |-> $past(tg_req && tg_hit && !ln_req && !dw_req)); // R8
    AST_RESULT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        tg_done |-> (tg_result[DW-1:TAG_W] == '0)); // R4
    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tg_done && !$past(tg_req)) |-> 1'b0); // R4
endmodule

// File: tb/tb_tagline_store.sv
`timescale 1ns/1ps
module tb_tagline_store;
    localparam int TAG_W = 4, WORDS = 8, SETS = 4, WAYS = 2;
    localparam int SLOT_W = 64 + TAG_W;
    localparam int LINE_W = WORDS * SLOT_W;
    localparam int LINES  = SETS * WAYS;

    typedef struct packed {
        logic [63:0] base;
        logic [11:0] imm;
        logic [63:0] src;
        logic [1:0]  set;
        logic        way;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{64'h1000,  12'h008, 64'h5,   2'd0, 1'b0},
        '{64'h1040,  12'hFF8, 64'hFFA, 2'd1, 1'b1},
        '{64'h0,     12'h7F8, 64'h3,   2'd2, 1'b0},
        '{64'h2003,  12'h005, 64'h9,   2'd3, 1'b1},
        '{64'h1000,  12'h004, 64'h7,   2'd0, 1'b0},
        '{64'h10,    12'h800, 64'hBC,  2'd1, 1'b0},
        '{64'h18,    12'h001, 64'h6,   2'd2, 1'b1},
        '{64'h30,    12'h000, 64'hF0,  2'd0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ln_req = 0, ln_we = 0; logic [1:0] ln_set = 0; logic ln_way = 0;
    logic [LINE_W-1:0] ln_wdata = '0, ln_rdata;
    logic dw_req = 0, dw_we = 0; logic [1:0] dw_set = 0; logic dw_way = 0;
    logic [2:0] dw_idx = 0; logic [63:0] dw_wdata = 0, dw_rdata;
    logic tg_req = 0, tg_st = 0, tg_hit = 0; logic [1:0] tg_set = 0; logic tg_way = 0;
    logic [63:0] tg_base = 0, tg_src = 0, tg_result; logic [11:0] tg_imm = 0;
    logic tg_done, tg_misalign;

    logic [63:0]      mdata [LINES][WORDS];
    logic [TAG_W-1:0] mtag  [LINES][WORDS];
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tagline_store #(.TAG_W(TAG_W), .WORDS(WORDS), .SETS(SETS), .WAYS(WAYS)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_line(input string req, input int l);
        logic [LINE_W-1:0] e;
        for (int w = 0; w < WORDS; w++) e[w*SLOT_W +: SLOT_W] = {mtag[l][w], mdata[l][w]};
        n_chk++;
        if (ln_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: actual line %h expected line %h", req, ln_rdata, e);
        end
    endtask

    function automatic logic [LINE_W-1:0] model_line(input int l);
        logic [LINE_W-1:0] r;
        for (int w = 0; w < WORDS; w++) r[w*SLOT_W +: SLOT_W] = {mtag[l][w], mdata[l][w]};
        return r;
    endfunction

    task automatic step();
        @(posedge clk); #1;
        ln_req = 0; dw_req = 0; tg_req = 0;
    endtask

    task automatic line_op(input logic we, input int l);
        @(negedge clk);
        ln_req = 1; ln_we = we; ln_set = 2'(l / WAYS); ln_way = 1'(l % WAYS);
        ln_wdata = model_line(l);
        step();
    endtask

    task automatic word_op(input logic we, input int l, input int w, input logic [63:0] d);
        @(negedge clk);
        dw_req = 1; dw_we = we; dw_set = 2'(l / WAYS); dw_way = 1'(l % WAYS);
        dw_idx = 3'(w); dw_wdata = d;
        step();
    endtask

    task automatic tag_op(input logic st, input logic hit, input int l,
                          input logic [63:0] b, input logic [11:0] i, input logic [63:0] s);
        @(negedge clk);
        tg_req = 1; tg_st = st; tg_hit = hit; tg_set = 2'(l / WAYS); tg_way = 1'(l % WAYS);
        tg_base = b; tg_imm = i; tg_src = s;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WORDS; w++) begin
                mdata[l][w] = {16'hC0DE, 16'(l), 16'hBEEF, 16'(w)};
                mtag[l][w]  = TAG_W'(l * 3 + w + 1);
            end
        repeat (3) @(posedge clk);
        #1;
        chk("R10 tg_done", 64'(tg_done), 0);
        chk("R10 tg_misalign", 64'(tg_misalign), 0);
        chk("R10 tg_result", tg_result, 0);
        chk("R10 dw_rdata", dw_rdata, 0);
        chk("R10 ln_rdata", 64'(ln_rdata == '0), 1);
        @(negedge clk); rst_n = 1;

        for (int l = 0; l < LINES; l++) line_op(1, l);
        line_op(0, 5);
        chk_line("R1 line roundtrip", 5);

        // Vector table: store-tag then load back at the aligned address.
        for (int v = 0; v < 8; v++) begin
            logic [63:0] ea; logic fault; int l, w;
            ea    = VECS[v].base + {{52{VECS[v].imm[11]}}, VECS[v].imm};
            fault = (ea[2:0] != 0);
            l     = int'(VECS[v].set) * WAYS + int'(VECS[v].way);
            w     = int'(ea[5:3]);
            tag_op(1, 1, l, VECS[v].base, VECS[v].imm, VECS[v].src);
            chk("R2/R5 store fault flag", 64'(tg_misalign), 64'(fault));
            chk("R5 store done flag", 64'(tg_done), 64'(!fault));
            if (!fault) mtag[l][w] = VECS[v].src[TAG_W-1:0];
            tag_op(0, 1, l, {ea[63:3], 3'b000}, 12'h000, 64'hFFFF);
            chk(fault ? "R5 tag unchanged" : "R3 tag stored", tg_result, 64'(mtag[l][w]));
            chk("R4 load done", 64'(tg_done), 1);
        end

        line_op(0, 0);
        chk_line("R1 tag slot position", 0);
        word_op(0, 0, 1, 0);
        chk("R6 data kept after tag store", dw_rdata, mdata[0][1]);

        mdata[3][4] = 64'h0123_4567_89AB_CDEF;
        word_op(1, 3, 4, 64'h0123_4567_89AB_CDEF);
        tag_op(0, 1, 3, 64'h20, 12'h000, 0);
        chk("R7 tag kept after word write", tg_result, 64'(mtag[3][4]));
        word_op(0, 3, 4, 0);
        chk("R7 word readback", dw_rdata, 64'h0123_4567_89AB_CDEF);

        tag_op(1, 0, 2, 64'h0, 12'h000, 64'hF);
        chk("R8 no done on miss", 64'(tg_done), 0);
        tag_op(0, 1, 2, 64'h0, 12'h000, 0);
        chk("R8 tag unchanged on miss", tg_result, 64'(mtag[2][0]));
        tag_op(0, 0, 2, 64'h2, 12'h000, 0);
        chk("R8 misalign on miss", 64'(tg_misalign), 1);

        mtag[6][2] = 4'hD;
        @(negedge clk);
        ln_req = 1; ln_we = 1; ln_set = 2'd3; ln_way = 1'b0; ln_wdata = model_line(6);
        tg_req = 1; tg_st = 1; tg_hit = 1; tg_set = 2'd3; tg_way = 1'b0;
        tg_base = 64'h10; tg_imm = 0; tg_src = 64'h2;
        step();
        chk("R9 tag port ignored done", 64'(tg_done), 0);
        tag_op(0, 1, 6, 64'h10, 12'h000, 0);
        chk("R9 line write wins", tg_result, 64'hD);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule